// File: doc/BRIEF.md
# Guarded Data Access Unit

This unit sits between an execution stage and the data memory. For each load or store it forms the effective address from a base register and an offset. The offset is either the instruction's immediate or a second register. Before any byte is touched, the unit checks the access. Addresses in a permanently forbidden low region end the program with a panic. Pages whose permissions do not allow the access produce a resumable page fault. Only an access that passes both checks reaches memory, as a 1-, 2- or 4-byte little-endian transfer.

On a fault the unit returns the address of the page that blocked the access and hands back the unchanged program counter, so the same instruction runs again. A supervising host can grant permissions through a write port into a per-page table of read and write bits and then restart execution. An access that straddles two pages is checked on both. A completed access advances the program counter by the instruction length and charges a fixed gas cost.

Each request returns its result one clock later. Memory is driven during that response cycle, and load data comes back from the memory's combinational read in the same cycle.

Top module: `mem_access_guard`

## Requirements
- R1: The effective address is `req_base` plus `req_off_reg` when `req_off_sel` is 1, or plus `req_off_imm` when it is 0, taken modulo 2^ADDR_W. On a completed access `mem_addr` equals that address.
- R2: If any byte of the access lies below PROT_LIMIT (default 0x10000), `resp_status` is 2'd1 (panic), whatever the table holds. The byte range is the effective address plus 0..n-1 with wraparound. A panic, like a fault, raises no `mem_en`.
- R3: If a load finds a page without its read bit, or a store finds a page without its write bit, `resp_status` is 2'd2 (fault). A page numbered NUM_PAGES or higher counts as unmapped. On a fault `resp_fault_addr` is the blocking byte's address with its low PAGE_BITS bits cleared; otherwise it is 0.
- R4: An access whose bytes span two pages is permitted only if both pages allow it. When both block it, the fault reports the page of the lowest-addressed byte.
- R5: After a panic or fault `resp_pc` equals the request's `req_pc`. After a completed access it equals `req_pc + req_len`.
- R6: `req_size` encodes 0 as 1 byte, 1 as 2 bytes, and 2 or 3 as 4 bytes. Load data is little-endian, with the byte at the effective address in bits 7:0, and zero-extended above the accessed bytes.
- R7: A completed store raises `mem_en` and `mem_we` and presents `mem_size`. `mem_wdata` carries the low n bytes of `req_wdata` in place, with upper bytes zero.
- R8: A completed access returns `resp_gas = req_gas - 2`. A panic or fault returns `req_gas` unchanged.
- R9: A host write (`host_we`, `host_page`, `host_rd`, `host_wr`) replaces both permission bits of one page from the next cycle on. A reissued request that faulted before then completes, while a page below PROT_LIMIT still panics.
- R10: After reset `resp_valid`, `mem_en` and `resp_data` are 0 and every page has neither permission.
- R11: `resp_valid` is 1 in exactly the cycles that follow a cycle with `req_valid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request present this cycle |
| req_store | input | 1 | 1 for store, 0 for load |
| req_size | input | 2 | Access size code (0:1 B, 1:2 B, 2/3:4 B) |
| req_base | input | ADDR_W | Base register value |
| req_off_imm | input | ADDR_W | Immediate offset |
| req_off_reg | input | ADDR_W | Register offset |
| req_off_sel | input | 1 | 1 selects the register offset |
| req_wdata | input | DATA_W | Store data |
| req_pc | input | PC_W | Program counter of the instruction |
| req_len | input | LEN_W | Instruction length in bytes |
| req_gas | input | GAS_W | Gas before the instruction |
| host_we | input | 1 | Permission table write strobe |
| host_page | input | IDX_W | Page number to update |
| host_rd | input | 1 | New read permission |
| host_wr | input | 1 | New write permission |
| resp_valid | output | 1 | Result present |
| resp_status | output | 2 | 0 done, 1 panic, 2 page fault |
| resp_fault_addr | output | ADDR_W | Faulting page address |
| resp_pc | output | PC_W | Next program counter |
| resp_gas | output | GAS_W | Gas after the instruction |
| resp_data | output | DATA_W | Zero-extended load data |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Byte address of first accessed byte |
| mem_size | output | 2 | Size code of the access |
| mem_wdata | output | DATA_W | Store data, unused bytes zero |
| mem_rdata | input | DATA_W | Memory read data, little-endian from mem_addr |

## Verification
The bench builds the unit with NUM_PAGES at 32 instead of 64, so the table ends at address 0x20000. That brings a page lying past the table's end within reach of a plain request, as the unmapped case. It keeps the default 4 KB pages and the 0x10000 protected limit, so a request starting at 0xFFFF exercises the panic that wins over a mapped neighbour. Page 16 is the first page that can be granted, and it neighbours page 17, so straddling accesses at 0x10FFE and 0x10FFF exercise each ordering of the two-page check. A base near the top of the address space exercises the wraparound into the forbidden region.

// File: rtl/mag_pkg.sv
package mag_pkg;

   typedef enum logic [1:0] {
      ACC_OK    = 2'd0,
      ACC_PANIC = 2'd1,
      ACC_FAULT = 2'd2
   } acc_status_e;

   // Byte count for a size code: 0 -> 1, 1 -> 2, otherwise 4.
   function automatic logic [2:0] span_bytes(input logic [1:0] code);
      case (code)
         2'd0:    return 3'd1;
         2'd1:    return 3'd2;
         default: return 3'd4;
      endcase
   endfunction

endpackage

// File: rtl/mag_addr_gen.sv
module mag_addr_gen #(
   parameter int ADDR_W    = 32,
   parameter int PAGE_BITS = 12,
   localparam int PN_W     = ADDR_W - PAGE_BITS
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [ADDR_W-1:0] off_imm,
   input  logic [ADDR_W-1:0] off_reg,
   input  logic              off_sel,
   input  logic [1:0]        size_code,
   output logic [ADDR_W-1:0] ea,
   output logic [ADDR_W-1:0] last_addr,
   output logic [PN_W-1:0]   first_pn,
   output logic [PN_W-1:0]   last_pn
);
   import mag_pkg::*;

   logic [ADDR_W-1:0] offset;
   logic [2:0]        extra;

   assign offset    = off_sel ? off_reg : off_imm;
   assign ea        = base + offset;
   assign extra     = span_bytes(size_code) - 3'd1;
   assign last_addr = ea + {{(ADDR_W-3){1'b0}}, extra};
   assign first_pn  = ea[ADDR_W-1:PAGE_BITS];
   assign last_pn   = last_addr[ADDR_W-1:PAGE_BITS];

endmodule

// File: rtl/mag_perm_table.sv
module mag_perm_table #(
   parameter int NUM_PAGES = 64,
   parameter int PN_W      = 20,
   parameter int NPORTS    = 2,
   localparam int IDX_W    = $clog2(NUM_PAGES)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_en,
   input  logic [IDX_W-1:0]            wr_idx,
   input  logic                        wr_rd,
   input  logic                        wr_wr,
   input  logic [NPORTS-1:0][PN_W-1:0] q_pn,
   output logic [NPORTS-1:0]           q_rd,
   output logic [NPORTS-1:0]           q_wr
);

   logic [NUM_PAGES-1:0] rd_bits;
   logic [NUM_PAGES-1:0] wr_bits;

   for (genvar g = 0; g < NUM_PAGES; g++) begin : g_page
      logic r_q;
      logic w_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            r_q <= 1'b0;
            w_q <= 1'b0;
         end else if (wr_en && (wr_idx == IDX_W'(g))) begin
            r_q <= wr_rd;
            w_q <= wr_wr;
         end
      end
      assign rd_bits[g] = r_q;
      assign wr_bits[g] = w_q;
   end

   for (genvar p = 0; p < NPORTS; p++) begin : g_port
      logic in_range;
      assign in_range = (q_pn[p][PN_W-1:IDX_W] == '0);
      assign q_rd[p]  = in_range & rd_bits[q_pn[p][IDX_W-1:0]];
      assign q_wr[p]  = in_range & wr_bits[q_pn[p][IDX_W-1:0]];
   end

endmodule

// File: rtl/mag_classify.sv
module mag_classify #(
   parameter int ADDR_W                  = 32,
   parameter int PAGE_BITS               = 12,
   parameter logic [ADDR_W-1:0] PROT_LIMIT = ADDR_W'(32'h10000),
   localparam int PN_W                   = ADDR_W - PAGE_BITS
) (
   input  logic                  is_store,
   input  logic [ADDR_W-1:0]     ea,
   input  logic [ADDR_W-1:0]     last_addr,
   input  logic [PN_W-1:0]       first_pn,
   input  logic [PN_W-1:0]       last_pn,
   input  logic [1:0]            rd_ok,
   input  logic [1:0]            wr_ok,
   output mag_pkg::acc_status_e  status,
   output logic [ADDR_W-1:0]     fault_addr
);
   import mag_pkg::*;

   logic allow_first;
   logic allow_last;
   logic forbidden;

   assign allow_first = is_store ? wr_ok[0] : rd_ok[0];
   assign allow_last  = is_store ? wr_ok[1] : rd_ok[1];
   // last_addr below the limit also covers a wrap past the top.
   assign forbidden   = (ea < PROT_LIMIT) || (last_addr < PROT_LIMIT);

   always_comb begin
      status     = ACC_OK;
      fault_addr = '0;
      if (forbidden) begin
         status = ACC_PANIC;
      end else if (!allow_first) begin
         status     = ACC_FAULT;
         fault_addr = {first_pn, {PAGE_BITS{1'b0}}};
      end else if (!allow_last) begin
         status     = ACC_FAULT;
         fault_addr = {last_pn, {PAGE_BITS{1'b0}}};
      end
   end

endmodule

// File: rtl/mag_lane_fmt.sv
module mag_lane_fmt #(
   parameter int DATA_W = 32,
   localparam int LANES = DATA_W / 8
) (
   input  logic [1:0]        size_code,
   input  logic [DATA_W-1:0] raw,
   output logic [DATA_W-1:0] shaped
);
   import mag_pkg::*;

   logic [2:0] nb;
   assign nb = span_bytes(size_code);

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic keep;
      assign keep            = (32'(i) < 32'(nb));
      assign shaped[8*i +: 8] = keep ? raw[8*i +: 8] : 8'h00;
   end

endmodule

// File: rtl/mem_access_guard.sv
module mem_access_guard #(
   parameter int ADDR_W                    = 32,
   parameter int DATA_W                    = 32,
   parameter int PAGE_BITS                 = 12,
   parameter int NUM_PAGES                 = 64,
   parameter logic [ADDR_W-1:0] PROT_LIMIT = ADDR_W'(32'h10000),
   parameter int PC_W                      = 32,
   parameter int LEN_W                     = 5,
   parameter int GAS_W                     = 64,
   parameter int ACCESS_GAS                = 2,
   localparam int IDX_W                    = $clog2(NUM_PAGES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_store,
   input  logic [1:0]        req_size,
   input  logic [ADDR_W-1:0] req_base,
   input  logic [ADDR_W-1:0] req_off_imm,
   input  logic [ADDR_W-1:0] req_off_reg,
   input  logic              req_off_sel,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [PC_W-1:0]   req_pc,
   input  logic [LEN_W-1:0]  req_len,
   input  logic [GAS_W-1:0]  req_gas,
   input  logic              host_we,
   input  logic [IDX_W-1:0]  host_page,
   input  logic              host_rd,
   input  logic              host_wr,
   output logic              resp_valid,
   output logic [1:0]        resp_status,
   output logic [ADDR_W-1:0] resp_fault_addr,
   output logic [PC_W-1:0]   resp_pc,
   output logic [GAS_W-1:0]  resp_gas,
   output logic [DATA_W-1:0] resp_data,
   output logic              mem_en,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [1:0]        mem_size,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata
);
   import mag_pkg::*;

   localparam int PN_W = ADDR_W - PAGE_BITS;

   if (DATA_W != 32) begin : g_bad_data_w
      $error("DATA_W must be 32 for 1/2/4-byte accesses");
   end
   if (PN_W <= IDX_W) begin : g_bad_page_bits
      $error("ADDR_W must leave more page-number bits than the table index");
   end
   if ((NUM_PAGES < 2) || ((NUM_PAGES & (NUM_PAGES - 1)) != 0)) begin : g_bad_pages
      $error("NUM_PAGES must be a power of two of at least 2");
   end
   if (PROT_LIMIT[PAGE_BITS-1:0] != '0) begin : g_bad_limit
      $error("PROT_LIMIT must be page aligned");
   end

   logic [ADDR_W-1:0] ea;
   logic [ADDR_W-1:0] last_addr;
   logic [PN_W-1:0]   first_pn;
   logic [PN_W-1:0]   last_pn;

   mag_addr_gen #(
      .ADDR_W    (ADDR_W),
      .PAGE_BITS (PAGE_BITS)
   ) u_addr (
      .base      (req_base),
      .off_imm   (req_off_imm),
      .off_reg   (req_off_reg),
      .off_sel   (req_off_sel),
      .size_code (req_size),
      .ea        (ea),
      .last_addr (last_addr),
      .first_pn  (first_pn),
      .last_pn   (last_pn)
   );

   logic [1:0][PN_W-1:0] q_pn;
   logic [1:0]           q_rd;
   logic [1:0]           q_wr;

   assign q_pn[0] = first_pn;
   assign q_pn[1] = last_pn;

   mag_perm_table #(
      .NUM_PAGES (NUM_PAGES),
      .PN_W      (PN_W),
      .NPORTS    (2)
   ) u_tbl (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (host_we),
      .wr_idx (host_page),
      .wr_rd  (host_rd),
      .wr_wr  (host_wr),
      .q_pn   (q_pn),
      .q_rd   (q_rd),
      .q_wr   (q_wr)
   );

   acc_status_e       st;
   logic [ADDR_W-1:0] flt_addr;

   mag_classify #(
      .ADDR_W     (ADDR_W),
      .PAGE_BITS  (PAGE_BITS),
      .PROT_LIMIT (PROT_LIMIT)
   ) u_cls (
      .is_store   (req_store),
      .ea         (ea),
      .last_addr  (last_addr),
      .first_pn   (first_pn),
      .last_pn    (last_pn),
      .rd_ok      (q_rd),
      .wr_ok      (q_wr),
      .status     (st),
      .fault_addr (flt_addr)
   );

   logic [DATA_W-1:0] wdata_shaped;
   logic [DATA_W-1:0] rdata_shaped;

   mag_lane_fmt #(.DATA_W(DATA_W)) u_wfmt (
      .size_code (req_size),
      .raw       (req_wdata),
      .shaped    (wdata_shaped)
   );

   mag_lane_fmt #(.DATA_W(DATA_W)) u_rfmt (
      .size_code (mem_size),
      .raw       (mem_rdata),
      .shaped    (rdata_shaped)
   );

   logic go;
   assign go = (st == ACC_OK);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         resp_valid      <= 1'b0;
         resp_status     <= 2'd0;
         resp_fault_addr <= '0;
         resp_pc         <= '0;
         resp_gas        <= '0;
         mem_en          <= 1'b0;
         mem_we          <= 1'b0;
         mem_addr        <= '0;
         mem_size        <= 2'd0;
         mem_wdata       <= '0;
      end else begin
         resp_valid <= req_valid;
         mem_en     <= req_valid && go;
         if (req_valid) begin
            resp_status     <= st;
            resp_fault_addr <= flt_addr;
            resp_pc         <= go ? (req_pc + PC_W'(req_len)) : req_pc;
            resp_gas        <= go ? (req_gas - GAS_W'(ACCESS_GAS)) : req_gas;
            mem_we          <= req_store && go;
            mem_addr        <= ea;
            mem_size        <= req_size;
            mem_wdata       <= req_store ? wdata_shaped : '0;
         end
      end
   end

   assign resp_data = (mem_en && !mem_we) ? rdata_shaped : '0;

endmodule

// File: rtl/mag_checker.sv
module mag_checker #(
   parameter int ADDR_W                    = 32,
   parameter int DATA_W                    = 32,
   parameter int PAGE_BITS                 = 12,
   parameter logic [ADDR_W-1:0] PROT_LIMIT = ADDR_W'(32'h10000),
   parameter int PC_W                      = 32,
   parameter int GAS_W                     = 64,
   parameter int ACCESS_GAS                = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [PC_W-1:0]   req_pc,
   input logic [GAS_W-1:0]  req_gas,
   input logic              resp_valid,
   input logic [1:0]        resp_status,
   input logic [ADDR_W-1:0] resp_fault_addr,
   input logic [PC_W-1:0]   resp_pc,
   input logic [GAS_W-1:0]  resp_gas,
   input logic [DATA_W-1:0] resp_data,
   input logic              mem_en,
   input logic              mem_we,
   input logic [1:0]        mem_size
);

   AST_RESP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> resp_valid); // R11

   AST_NO_SPURIOUS_RESP: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !resp_valid); // R11

   AST_MEM_ONLY_WHEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_en |-> (resp_valid && resp_status == 2'd0)); // R2

   AST_FAULT_PAGE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid && resp_status == 2'd2) |->
         (resp_fault_addr[PAGE_BITS-1:0] == '0 && resp_fault_addr >= PROT_LIMIT)); // R3

   AST_PC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (resp_status == 2'd0 || resp_pc == $past(req_pc))); // R5

   AST_GAS_CHARGE: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (resp_status != 2'd0 ||
                     resp_gas == $past(req_gas) - GAS_W'(ACCESS_GAS))); // R8

   AST_BYTE_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_en && !mem_we && mem_size == 2'd0) |-> (resp_data[DATA_W-1:8] == '0)); // R6

endmodule

bind mem_access_guard mag_checker #(
   .ADDR_W     (ADDR_W),
   .DATA_W     (DATA_W),
   .PAGE_BITS  (PAGE_BITS),
   .PROT_LIMIT (PROT_LIMIT),
   .PC_W       (PC_W),
   .GAS_W      (GAS_W),
   .ACCESS_GAS (ACCESS_GAS)
) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .req_valid       (req_valid),
   .req_pc          (req_pc),
   .req_gas         (req_gas),
   .resp_valid      (resp_valid),
   .resp_status     (resp_status),
   .resp_fault_addr (resp_fault_addr),
   .resp_pc         (resp_pc),
   .resp_gas        (resp_gas),
   .resp_data       (resp_data),
   .mem_en          (mem_en),
   .mem_we          (mem_we),
   .mem_size        (mem_size)
);

// File: tb/sim_mem_access_guard.sv
module sim_mem_access_guard;

   localparam int NP = 32;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic        rst_n;
   logic        req_valid, req_store, req_off_sel;
   logic [1:0]  req_size;
   logic [31:0] req_base, req_off_imm, req_off_reg, req_wdata, req_pc;
   logic [4:0]  req_len;
   logic [63:0] req_gas;
   logic        host_we, host_rd, host_wr;
   logic [4:0]  host_page;
   logic        resp_valid;
   logic [1:0]  resp_status;
   logic [31:0] resp_fault_addr, resp_pc, resp_data;
   logic [63:0] resp_gas;
   logic        mem_en, mem_we;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;
   logic [1:0]  mem_size;

   mem_access_guard #(.NUM_PAGES(NP)) u0 (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_store(req_store), .req_size(req_size),
      .req_base(req_base), .req_off_imm(req_off_imm), .req_off_reg(req_off_reg),
      .req_off_sel(req_off_sel), .req_wdata(req_wdata), .req_pc(req_pc),
      .req_len(req_len), .req_gas(req_gas),
      .host_we(host_we), .host_page(host_page), .host_rd(host_rd), .host_wr(host_wr),
      .resp_valid(resp_valid), .resp_status(resp_status),
      .resp_fault_addr(resp_fault_addr), .resp_pc(resp_pc), .resp_gas(resp_gas),
      .resp_data(resp_data),
      .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   int errors = 0;
   int checks = 0;

   logic [7:0] bmem [0:1023];
   logic [7:0] rmem [0:1023];
   bit         rperm [0:NP-1];
   bit         wperm [0:NP-1];

   initial begin
      for (int i = 0; i < 1024; i++) begin
         bmem[i] = 8'(i * 7 + 3);
         rmem[i] = 8'(i * 7 + 3);
      end
      for (int p = 0; p < NP; p++) begin
         rperm[p] = 1'b0;
         wperm[p] = 1'b0;
      end
   end

   assign mem_rdata = {bmem[mem_addr[9:0] + 10'd3], bmem[mem_addr[9:0] + 10'd2],
                       bmem[mem_addr[9:0] + 10'd1], bmem[mem_addr[9:0]]};

   always @(posedge clk) begin
      if (mem_en && mem_we) begin
         bmem[mem_addr[9:0]] <= mem_wdata[7:0];
         if (mem_size != 2'd0) bmem[mem_addr[9:0] + 10'd1] <= mem_wdata[15:8];
         if (mem_size[1]) begin
            bmem[mem_addr[9:0] + 10'd2] <= mem_wdata[23:16];
            bmem[mem_addr[9:0] + 10'd3] <= mem_wdata[31:24];
         end
      end
   end

   task automatic chk(input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   function automatic int nbytes(input logic [1:0] s);
      return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
   endfunction

   task automatic model(input bit st, input logic [1:0] sz, input logic [31:0] ea,
                        output int status, output logic [31:0] page);
      status = 0;
      page   = 32'h0;
      for (int i = 0; i < nbytes(sz); i++) begin
         logic [31:0] a;
         a = ea + 32'(i);
         if (a < 32'h10000) status = 1;
      end
      if (status == 0) begin
         for (int i = 0; i < nbytes(sz); i++) begin
            logic [31:0] a;
            int unsigned pn;
            bit allowed;
            a  = ea + 32'(i);
            pn = a >> 12;
            allowed = (pn < NP) && (st ? wperm[pn] : rperm[pn]);
            if (!allowed && status == 0) begin
               status = 2;
               page   = a & ~32'hFFF;
            end
         end
      end
   endtask

   task automatic set_perm(input int idx, input bit r, input bit w);
      @(negedge clk);
      host_we = 1'b1; host_page = 5'(idx); host_rd = r; host_wr = w;
      @(negedge clk);
      host_we = 1'b0;
      rperm[idx] = r;
      wperm[idx] = w;
   endtask

   task automatic access(input string tag, input bit st, input logic [1:0] sz,
                         input logic [31:0] base, input logic [31:0] off,
                         input bit sel, input logic [31:0] wd);
      logic [31:0] ea, page, pc, expd, expw;
      logic [63:0] gas;
      int status;
      int nb;
      nb  = nbytes(sz);
      ea  = base + off;
      pc  = 32'h400 + 32'(checks * 4);
      gas = 64'd1000 + 64'(checks);
      model(st, sz, ea, status, page);
      @(negedge clk);
      req_valid = 1'b1; req_store = st; req_size = sz; req_base = base;
      req_off_sel = sel;
      req_off_imm = sel ? 32'hDEAD0000 : off;
      req_off_reg = sel ? off : 32'h0BEEF000;
      req_wdata = wd; req_pc = pc; req_len = 5'd3; req_gas = gas;
      @(posedge clk); #5;
      chk("R11", "resp_valid", 64'(resp_valid), 64'd1);
      chk(tag, "status", 64'(resp_status), 64'(status));
      chk(tag, "fault page", 64'(resp_fault_addr), 64'(page));
      chk("R5", "next pc", 64'(resp_pc), 64'((status == 0) ? pc + 32'd3 : pc));
      chk("R8", "gas", resp_gas, (status == 0) ? gas - 64'd2 : gas);
      chk("R2", "mem_en", 64'(mem_en), 64'(status == 0));
      if (status == 0) begin
         chk("R1", "mem_addr", 64'(mem_addr), 64'(ea));
         chk("R7", "mem_we", 64'(mem_we), 64'(st));
         expd = 32'h0;
         expw = 32'h0;
         for (int i = 0; i < nb; i++) begin
            expd[8*i +: 8] = rmem[10'(ea + 32'(i))];
            expw[8*i +: 8] = wd[8*i +: 8];
         end
         if (st) begin
            chk("R7", "mem_wdata", 64'(mem_wdata), 64'(expw));
            chk("R7", "mem_size", 64'(mem_size), 64'(sz));
            for (int i = 0; i < nb; i++) rmem[10'(ea + 32'(i))] = wd[8*i +: 8];
         end else begin
            chk("R6", "load data", 64'(resp_data), 64'(expd));
         end
      end
      @(negedge clk);
      req_valid = 1'b0;
      @(posedge clk); #5;
      chk("R11", "idle resp_valid", 64'(resp_valid), 64'd0);
   endtask

   initial begin
      #(64'd20 * 64'd200000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      req_valid = 1'b0; req_store = 1'b0; req_size = 2'd0; req_base = '0;
      req_off_imm = '0; req_off_reg = '0; req_off_sel = 1'b0; req_wdata = '0;
      req_pc = '0; req_len = '0; req_gas = '0;
      host_we = 1'b0; host_page = '0; host_rd = 1'b0; host_wr = 1'b0;
      repeat (3) @(posedge clk);
      #5;
      chk("R10", "reset resp_valid", 64'(resp_valid), 64'd0);
      chk("R10", "reset mem_en", 64'(mem_en), 64'd0);
      chk("R10", "reset resp_data", 64'(resp_data), 64'd0);
      @(negedge clk);
      rst_n = 1'b1;

      // R2: low region panics
      access("R2", 1'b0, 2'd2, 32'h00008000, 32'h0, 1'b0, 32'h0);
      set_perm(0, 1'b1, 1'b1);
      access("R9", 1'b0, 2'd0, 32'h00000100, 32'h0, 1'b0, 32'h0);
      // R10: table cleared, so page 16 faults first
      access("R10", 1'b0, 2'd2, 32'h00010000, 32'h4, 1'b0, 32'h0);
      set_perm(16, 1'b1, 1'b1);
      // R9: reissue after mapping completes
      access("R9", 1'b1, 2'd2, 32'h00010000, 32'h4, 1'b0, 32'hA1B2C3D4);
      access("R6", 1'b0, 2'd0, 32'h00010001, 32'h4, 1'b1, 32'h0);
      access("R6", 1'b0, 2'd1, 32'h00010000, 32'h6, 1'b1, 32'h0);
      access("R6", 1'b0, 2'd2, 32'h00010004, 32'h0, 1'b0, 32'h0);
      access("R1", 1'b0, 2'd2, 32'h00010010, 32'hFFFFFFF4, 1'b0, 32'h0);
      // R3: read-only page blocks stores
      set_perm(17, 1'b1, 1'b0);
      access("R3", 1'b1, 2'd0, 32'h00011000, 32'h8, 1'b0, 32'h55);
      access("R3", 1'b0, 2'd0, 32'h00011000, 32'h8, 1'b0, 32'h0);
      // R4: page crossing
      access("R4", 1'b0, 2'd2, 32'h00010FFE, 32'h0, 1'b0, 32'h0);
      access("R4", 1'b1, 2'd2, 32'h00010FFE, 32'h0, 1'b0, 32'h11223344);
      set_perm(16, 1'b1, 1'b0);
      access("R4", 1'b1, 2'd1, 32'h00010FFF, 32'h0, 1'b0, 32'h6677);
      // R3: beyond the table
      access("R3", 1'b0, 2'd0, 32'h00020000, 32'h0, 1'b0, 32'h0);
      // R2: wrap and straddle of the limit
      access("R2", 1'b0, 2'd2, 32'hFFFFFFFE, 32'h0, 1'b0, 32'h0);
      access("R2", 1'b0, 2'd1, 32'h0000FFFF, 32'h0, 1'b0, 32'h0);
      // R7: two-byte store, then read back
      set_perm(16, 1'b1, 1'b1);
      access("R7", 1'b1, 2'd1, 32'h00010020, 32'h2, 1'b1, 32'hFFFF9A8B);
      access("R7", 1'b0, 2'd2, 32'h00010020, 32'h0, 1'b0, 32'h0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule